// File: doc/BRIEF.md
# CPU Clock Ratio Generator

This block turns one of several PLL tick streams into four related CPU-domain clock enables. Everything runs in a single system clock domain. A PLL "tick" is a one-cycle-high input, and each output is a one-cycle enable pulse, so no generated clocks exist. A control register picks the source, sets a one-based main divisor and holds one gate bit per output.

The divided tick is the fastest output. Three fixed post-dividers count off that divided tick. A one-bit ratio-mode input chooses the ratio family, either 6:3:2:1 (mode 1) or 4:2:2:1 (mode 0), expressed as rates relative to the slowest output. A divisor change applies at the next divided-tick boundary. A mode change applies at the next slowest-output boundary. Together these keep every output phase-aligned and never shorten a pulse.

Top module: `cpu_ratio_gen`

## Requirements
- R1: During and after reset, `rd_data` reads 0x0F000100 (select 0, divisor 1, all four gates on) and `en_out` is 0.
- R2: A write stores select bits [5:4], divisor bits [13:8] and gate bits [27:24]; `rd_data` returns them, and every other bit reads 0 (writing 0xFFFFFFFF reads back 0x0F003F30).
- R3: Select code 0 or 1 takes `src_tick[0]`, code 2 takes `src_tick[1]`, code 3 takes `src_tick[2]`; ticks on unselected inputs have no effect.
- R4: With divisor field N, output 0 pulses once every N selected ticks; N=0 behaves exactly as N=1.
- R5: Output 1 pulses every 2 divided ticks, output 2 every 2+mode, output 3 every 4+2*mode.
- R6: Gate bit 24+k enables output k; with the bit clear, output k stays 0.
- R7: Outputs are registered: a pulse appears on the clock edge after the edge that sampled the selected tick that caused it.
- R8: All post-dividers start together, so the first divided tick after reset pulses all gated outputs, and every output-3 pulse coincides with pulses on outputs 0, 1 and 2.
- R9: A new divisor takes effect only after the divided tick that ends the period in progress.
- R10: A change of `ratio_mode` takes effect only from the divided tick that follows an output-3 pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register contents |
| ratio_mode | input | 1 | 0: 4:2:2:1 family, 1: 6:3:2:1 family |
| src_tick | input | 3 | Tick streams A, B, C |
| en_out | output | 4 | Gated enable pulses, bit 0 fastest |

## Verification
Register writes appear on `rd_data` one cycle after the write edge. The bench reads them back at the following falling edge. An enable pulse is due exactly one clock after the edge that samples the selected tick that completes its count. A reference model in the bench advances on the same rising edge from the inputs the bench drove at the previous falling edge. Every output bit is compared against that model at each falling edge. New inputs are driven only after that comparison, so the expected pulse and the observed pulse always refer to the same cycle.

// File: rtl/cpu_ratio_pkg.sv
package cpu_ratio_pkg;
  localparam int CTRL_W   = 32;
  localparam int SEL_LSB  = 4;
  localparam int SEL_W    = 2;
  localparam int DIV_LSB  = 8;
  localparam int DIV_W    = 6;
  localparam int GATE_LSB = 24;
  localparam int NUM_OUT  = 4;
  localparam int NUM_SRC  = 3;

  localparam logic [CTRL_W-1:0] RST_CTRL =
    (CTRL_W'({NUM_OUT{1'b1}}) << GATE_LSB) | (CTRL_W'(1) << DIV_LSB);

  // post-divider k ratio = base + step * mode
  function automatic int post_base(input int k);
    return (k == NUM_OUT - 1) ? 4 : 2;
  endfunction

  function automatic int post_step(input int k);
    return (k == 1) ? 0 : ((k == 2) ? 1 : 2);
  endfunction
endpackage

// File: rtl/ratio_src_sel.sv
module ratio_src_sel
  import cpu_ratio_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] ticks,
  output logic               tick
);
  always_comb begin
    case (sel)
      2'd2:    tick = ticks[1];
      2'd3:    tick = ticks[2];
      default: tick = ticks[0];
    endcase
  end
endmodule

// File: rtl/ratio_main_div.sv
module ratio_main_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_tick,
  input  logic [W-1:0] div_field,
  output logic         div_tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff_div;
  logic         at_last;

  assign at_last  = (cnt == eff_div - W'(1));
  assign div_tick = src_tick && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      eff_div <= W'(1);
    end else if (src_tick) begin
      if (at_last) begin
        cnt     <= '0;
        eff_div <= (div_field == '0) ? W'(1) : div_field;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end

  // R4
  cnt_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < eff_div);
  // R4
  eff_div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    eff_div != '0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !src_tick |=> ($stable(cnt) && $stable(eff_div)));
endmodule

// File: rtl/ratio_post_div.sv
module ratio_post_div #(
  parameter int BASE = 2,
  parameter int STEP = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  input  logic mode,
  output logic pulse,
  output logic at_zero
);
  localparam int RMAX = BASE + STEP;
  localparam int CW   = $clog2(RMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last    = mode ? CW'(RMAX - 1) : CW'(BASE - 1);
  assign at_zero = (cnt == '0);
  assign pulse   = step_in && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step_in) begin
      cnt <= (cnt >= last) ? '0 : cnt + CW'(1);
    end
  end

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(RMAX - 1));
endmodule

// File: rtl/cpu_ratio_gen.sv
module cpu_ratio_gen
  import cpu_ratio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  rd_data,
  input  logic               ratio_mode,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [NUM_OUT-1:0] en_out
);
  logic [SEL_W-1:0]   sel_q;
  logic [DIV_W-1:0]   div_q;
  logic [NUM_OUT-1:0] gate_q;
  logic               eff_mode;
  logic               sel_tick;
  logic               div_tick;
  logic [NUM_OUT-1:0] post_pulse;
  logic [NUM_OUT-1:0] post_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RST_CTRL[SEL_LSB +: SEL_W];
      div_q  <= RST_CTRL[DIV_LSB +: DIV_W];
      gate_q <= RST_CTRL[GATE_LSB +: NUM_OUT];
    end else if (wr_en) begin
      sel_q  <= wr_data[SEL_LSB +: SEL_W];
      div_q  <= wr_data[DIV_LSB +: DIV_W];
      gate_q <= wr_data[GATE_LSB +: NUM_OUT];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: SEL_W]    = sel_q;
    rd_data[DIV_LSB +: DIV_W]    = div_q;
    rd_data[GATE_LSB +: NUM_OUT] = gate_q;
  end

  ratio_src_sel u_sel (
    .sel   (sel_q),
    .ticks (src_tick),
    .tick  (sel_tick)
  );

  ratio_main_div #(.W(DIV_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (sel_tick),
    .div_field (div_q),
    .div_tick  (div_tick)
  );

  assign post_pulse[0] = div_tick;
  assign post_zero[0]  = 1'b1;

  for (genvar k = 1; k < NUM_OUT; k++) begin : g_post
    ratio_post_div #(.BASE(post_base(k)), .STEP(post_step(k))) u_post (
      .clk     (clk),
      .rst     (rst),
      .step_in (div_tick),
      .mode    (eff_mode),
      .pulse   (post_pulse[k]),
      .at_zero (post_zero[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_mode <= 1'b0;
      en_out   <= '0;
    end else begin
      if (div_tick && post_zero[NUM_OUT-1]) eff_mode <= ratio_mode;
      en_out <= gate_q & post_pulse;
    end
  end

  // R1
  rst_readback_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == RST_CTRL && en_out == '0));
  // R8
  align_chk: assert property (@(posedge clk) disable iff (rst)
    post_pulse[NUM_OUT-1] |-> (&post_pulse[NUM_OUT-2:0]));
  // R6
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en_out & ~$past(gate_q)) == '0);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    en_out[0] |-> $past(div_tick));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(div_tick && post_zero[NUM_OUT-1]) |=> $stable(eff_mode));
endmodule

// File: tb/cpu_ratio_gen_bench.sv
module cpu_ratio_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ratio_mode = 1'b0;
  logic [2:0]  src_tick = '0;
  logic [3:0]  en_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_sel, m_div, m_cnt, m_eff, m_k, m_mode;
  logic [3:0] m_gate, m_exp;

  cpu_ratio_gen u_cpu_ratio_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ratio_mode(ratio_mode), .src_tick(src_tick),
    .en_out(en_out)
  );

  always #10 clk = ~clk;

  function automatic bit pick(input int sel, input logic [2:0] t);
    if (sel == 2) return t[1];
    if (sel == 3) return t[2];
    return t[0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sel = 0; m_div = 1; m_gate = 4'hF;
      m_cnt = 0; m_eff = 1; m_k = 0; m_mode = 0; m_exp = '0;
    end else begin
      logic [3:0] e;
      e = '0;
      if (pick(m_sel, src_tick)) begin
        if (m_cnt + 1 >= m_eff) begin
          int r3, old_k;
          r3 = 4 + 2 * m_mode;
          e[0] = 1'b1;
          e[1] = (m_k % 2 == 0);
          e[2] = (m_k % (2 + m_mode) == 0);
          e[3] = (m_k % r3 == 0);
          old_k = m_k;
          m_k = (m_k + 1) % r3;
          if (old_k == 0) m_mode = ratio_mode;
          m_cnt = 0;
          m_eff = (m_div == 0) ? 1 : m_div;
        end else begin
          m_cnt++;
        end
      end
      m_exp = e & m_gate;
      if (wr_en) begin
        m_sel = int'(wr_data[5:4]);
        m_div = int'(wr_data[13:8]);
        m_gate = wr_data[27:24];
      end
    end
  end

  task automatic chk(input bit ok, input string t, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d",
               t, act, exp, cycles);
    end
  endtask

  // one cycle: compare at falling edge, caller drives inputs afterwards
  task automatic cyc();
    @(negedge clk);
    chk(en_out == m_exp, tag, 32'(en_out), 32'(m_exp));
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input logic [2:0] t);
    for (int i = 0; i < n; i++) begin
      src_tick = t;
      cyc();
    end
    src_tick = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; src_tick = '0; wr_en = 1'b0; ratio_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 32'h0F00_0100, "R1", rd_data, 32'h0F00_0100);
    chk(en_out == 4'h0, "R1", 32'(en_out), 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(1234));
    do_reset();

    // R2 readback and unused bits
    tag = "R2";
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk(rd_data == 32'h0F00_3F30, "R2", rd_data, 32'h0F00_3F30);
    do_reset();

    // R8 first divided tick pulses everything
    tag = "R8";
    ticks(1, 3'b001);
    cyc();
    ticks(12, 3'b001);

    // R3 select codes, unselected inputs ignored
    tag = "R3";
    wr(32'h0F00_0120);
    ticks(4, 3'b101);
    ticks(3, 3'b010);
    wr(32'h0F00_0130);
    ticks(4, 3'b011);
    ticks(3, 3'b100);
    wr(32'h0F00_0110);
    ticks(4, 3'b110);
    ticks(3, 3'b001);

    // R7 one-cycle latency, isolated tick
    tag = "R7";
    wr(32'h0F00_0100);
    src_tick = 3'b001;
    cyc();
    src_tick = '0;
    cyc();
    chk(en_out[0] == 1'b0, "R7", 32'(en_out), 32'h0);
    cyc();

    // R4 divisor 3 then divisor 0
    tag = "R4";
    wr(32'h0F00_0300);
    ticks(3, 3'b001);
    ticks(30, 3'b001);
    wr(32'h0F00_0000);
    ticks(24, 3'b001);

    // R5 both ratio families
    tag = "R5";
    wr(32'h0F00_0100);
    ratio_mode = 1'b0;
    ticks(30, 3'b001);
    ratio_mode = 1'b1;
    ticks(40, 3'b001);

    // R10 toggle mode mid-period
    tag = "R10";
    for (int i = 0; i < 20; i++) begin
      ratio_mode = ~ratio_mode;
      ticks(3 + (i % 4), 3'b001);
    end

    // R6 gates
    tag = "R6";
    wr(32'h0500_0100);
    ticks(24, 3'b001);
    wr(32'h0000_0100);
    ticks(12, 3'b001);

    // R9 divisor change mid-period
    tag = "R9";
    wr(32'h0F00_0500);
    ticks(7, 3'b001);
    wr(32'h0F00_0200);
    ticks(20, 3'b001);

    // random mix
    tag = "R4 R5 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      src_tick = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 60) == 0) ratio_mode = ~ratio_mode;
      if ($urandom_range(0, 80) == 0) begin
        d = $urandom;
        d[13:8] = 6'($urandom_range(0, 4));
        if ($urandom_range(0, 3) != 0) d[27:24] = 4'hF;
        wr_en = 1'b1; wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      cyc();
    end
    wr_en = 1'b0; src_tick = '0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule